// File: doc/BRIEF.md
# ADC Conversion Chain Sequencer

This block is the control engine that sits in front of a multi-channel successive-approximation converter. It walks a list of channels selected by a bit mask and hands them to the converter one at a time. For each conversion it raises a one-cycle start pulse with a channel number, then waits for the converter's done strobe. Two kinds of chain share the converter. A normal chain runs once or repeats continuously. An injected chain is started by software or by an edge on an external trigger, and it takes priority at the next gap between conversions.

Software-side controls are plain level or pulse inputs. Start inputs act on their rising edge. Abort inputs are one-cycle pulses that arm a pending flag. The power-down input is a level. The block reports its phase on a 3-bit status code, the channel in use, whether each chain type is active, and the pending and aborted flags.

Top module: `adc_chain_seq`

## Requirements
- R1: Channels of a chain are requested in ascending index order, and any channel whose mask bit is 0 is skipped. Each request is a one-cycle `conv_start_o` pulse that carries the channel on `conv_chan_o`.
- R2: A rising edge on `norm_start_i` with `scan_mode_i`=0 converts every channel set in `norm_mask_i` exactly once. `norm_busy_o` then returns to 0.
- R3: A chain whose mask is all zeros issues no request and ends (busy back to 0) within three cycles.
- R4: With `scan_mode_i`=1 the normal chain restarts from the lowest enabled channel after its last channel completes. Lowering `norm_start_i` lets the running pass finish and then stops, so the total count is a whole number of passes.
- R5: `norm_busy_o` stays 1 while a started normal chain is waiting behind an injected chain.
- R6: A rising edge on `inj_start_i` converts the channels set in `inj_mask_i`. Lowering `inj_start_i` while that chain runs has no effect on it.
- R7: An injected request that arrives during a normal conversion is served after that conversion completes. The normal chain then resumes at its next unconverted channel.
- R8: With `inj_trig_en_i`=1 an edge on `inj_trig_i` starts the injected chain. `inj_edge_i`=1 selects the rising edge and 0 selects the falling edge. With `inj_trig_en_i`=0 the trigger is ignored.
- R9: An `abort_conv_i` pulse during a conversion raises `conv_abort_o` and drops only that conversion. The next enabled channel is still requested, and `abort_conv_pend_o` clears at the next request.
- R10: An `abort_chain_i` pulse during a conversion ends the whole chain that conversion belongs to. `abort_chain_pend_o` stays set until the next request. Aborting an injected conversion sets `inj_aborted_o`, which clears when a new injected chain is accepted.
- R11: Holding `pwdn_i`=1 while no chain is active moves the status to 001 (powered down). Releasing it gives status 010 (waking) for WAKE_CYC cycles, then 000.
- R12: Status codes are 000 idle, 100 sampling (the cycle of the start pulse) and 110 converting. After reset the status is 000 and both busy flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| norm_start_i | input | 1 | Normal chain start level (rising edge starts) |
| scan_mode_i | input | 1 | 1 = continuous scan, 0 = one pass |
| norm_mask_i | input | NCH | Normal chain channel enables |
| inj_start_i | input | 1 | Injected chain software start (rising edge) |
| inj_trig_en_i | input | 1 | Enable external injection trigger |
| inj_edge_i | input | 1 | Trigger polarity: 1 rising, 0 falling |
| inj_trig_i | input | 1 | External injection trigger |
| inj_mask_i | input | NCH | Injected chain channel enables |
| abort_conv_i | input | 1 | Pulse: abort the current conversion |
| abort_chain_i | input | 1 | Pulse: abort the current chain |
| pwdn_i | input | 1 | Power-down request level |
| conv_done_i | input | 1 | Converter done strobe |
| conv_start_o | output | 1 | Converter start pulse |
| conv_chan_o | output | CW | Channel for the converter |
| conv_abort_o | output | 1 | Tells the converter to drop the current conversion |
| norm_busy_o | output | 1 | Normal chain running or pending |
| inj_busy_o | output | 1 | Injected chain running |
| inj_aborted_o | output | 1 | An injected conversion was aborted |
| abort_conv_pend_o | output | 1 | Single-conversion abort armed |
| abort_chain_pend_o | output | 1 | Chain abort armed |
| chan_addr_o | output | CW | Channel in use or last used |
| status_o | output | 3 | Phase code |

## Verification
The hardest situation to reach is an injected request that lands in the middle of a normal conversion. The bench must then confirm both the pre-emption point and the resume channel, and show that the normal busy flag stays high during the wait. The stimulus gets there by watching the converter start pulses at the ports: it pulses the injected start one cycle after the first normal request has been seen, while the converter model still holds that conversion open. Aborts use the same timing, and random masks with random converter latencies exercise the ordering rule over many channel patterns.

// File: rtl/adc_seq_pkg.sv
// Package: shared state encoding for the conversion chain sequencer.
// The state value is exported directly as the status code, so the
// encodings below are part of the block's visible behaviour.
package adc_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'b000,
        ST_PWDN   = 3'b001,
        ST_WAKE   = 3'b010,
        ST_SAMPLE = 3'b100,
        ST_CONV   = 3'b110
    } seq_state_e;
endpackage

// File: rtl/adc_seq_pick.sv
// adc_seq_pick: finds the lowest set mask bit at or above a start index.
// Purely combinational. Assumes FROM may equal NCH, meaning "past the end".
module adc_seq_pick #(
    parameter int NCH = 8,
    parameter int CW  = 3,
    parameter int PW  = 4
) (
    input  logic [NCH-1:0] mask,
    input  logic [PW-1:0]  from,
    output logic           found,
    output logic [CW-1:0]  idx
);
    // Scan from the top down so the last hit is the lowest qualifying index.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i] && (PW'(i) >= from)) begin
                found = 1'b1;
                idx   = CW'(i);
            end
        end
    end
endmodule

// File: rtl/adc_seq_trig.sv
// adc_seq_trig: edge detector for the external injection trigger.
// Emits a one-cycle pulse on the selected edge when enabled.
// Assumes the trigger is already synchronous to clk.
module adc_seq_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic rise_sel,
    input  logic trig_i,
    output logic go_o
);
    logic prev_q;

    // Remember the previous trigger level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= trig_i;
    end

    // Select the rising or falling edge and gate it with the enable.
    always_comb begin
        go_o = en & (rise_sel ? (trig_i & ~prev_q) : (~trig_i & prev_q));
    end
endmodule

// File: rtl/adc_chain_seq.sv
// adc_chain_seq: sequencer for normal and injected conversion chains
// sharing one converter. Decisions are made only in the idle gap between
// conversions. Injected chains win that gap, and each chain keeps its own
// resume pointer. Assumes the converter answers each start with one done
// strobe, unless it is told to abort.
module adc_chain_seq
    import adc_seq_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int WAKE_CYC = 4,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int PW = $clog2(NCH + 1),
    localparam int WW = $clog2(WAKE_CYC + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           norm_start_i,
    input  logic           scan_mode_i,
    input  logic [NCH-1:0] norm_mask_i,
    input  logic           inj_start_i,
    input  logic           inj_trig_en_i,
    input  logic           inj_edge_i,
    input  logic           inj_trig_i,
    input  logic [NCH-1:0] inj_mask_i,
    input  logic           abort_conv_i,
    input  logic           abort_chain_i,
    input  logic           pwdn_i,
    input  logic           conv_done_i,
    output logic           conv_start_o,
    output logic [CW-1:0]  conv_chan_o,
    output logic           conv_abort_o,
    output logic           norm_busy_o,
    output logic           inj_busy_o,
    output logic           inj_aborted_o,
    output logic           abort_conv_pend_o,
    output logic           abort_chain_pend_o,
    output logic [CW-1:0]  chan_addr_o,
    output logic [2:0]     status_o
);
    seq_state_e    state;
    logic          norm_run, inj_run, cur_inj;
    logic [PW-1:0] norm_ptr, inj_ptr;
    logic [CW-1:0] chan_q;
    logic          ab_conv_q, ab_chain_q, inj_abt_q;
    logic          norm_start_d, inj_start_d;
    logic [WW-1:0] wake_cnt;

    logic          norm_found, inj_found, ext_go, norm_go, inj_go, kill;
    logic [CW-1:0] norm_idx, inj_idx;

    adc_seq_pick #(.NCH(NCH), .CW(CW), .PW(PW)) u_pick_norm (
        .mask(norm_mask_i), .from(norm_ptr), .found(norm_found), .idx(norm_idx)
    );

    adc_seq_pick #(.NCH(NCH), .CW(CW), .PW(PW)) u_pick_inj (
        .mask(inj_mask_i), .from(inj_ptr), .found(inj_found), .idx(inj_idx)
    );

    adc_seq_trig u_trig (
        .clk(clk), .rst_n(rst_n), .en(inj_trig_en_i), .rise_sel(inj_edge_i),
        .trig_i(inj_trig_i), .go_o(ext_go)
    );

    // Request edges and the abort kill condition.
    always_comb begin
        norm_go = norm_start_i & ~norm_start_d;
        inj_go  = (inj_start_i & ~inj_start_d) | ext_go;
        kill    = (state == ST_CONV) & (ab_conv_q | ab_chain_q);
    end

    // Main control: phase, chain activity, pointers and channel latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            norm_run <= 1'b0;
            inj_run  <= 1'b0;
            cur_inj  <= 1'b0;
            norm_ptr <= '0;
            inj_ptr  <= '0;
            chan_q   <= '0;
            wake_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (pwdn_i && !norm_run && !inj_run) begin
                        state <= ST_PWDN;
                    end else if (inj_run) begin
                        if (inj_found) begin
                            chan_q  <= inj_idx;
                            inj_ptr <= PW'(inj_idx) + PW'(1);
                            cur_inj <= 1'b1;
                            state   <= ST_SAMPLE;
                        end else begin
                            inj_run <= 1'b0;
                        end
                    end else if (norm_run) begin
                        if (norm_found) begin
                            chan_q   <= norm_idx;
                            norm_ptr <= PW'(norm_idx) + PW'(1);
                            cur_inj  <= 1'b0;
                            state    <= ST_SAMPLE;
                        end else if (scan_mode_i && norm_start_i) begin
                            norm_ptr <= '0;
                        end else begin
                            norm_run <= 1'b0;
                        end
                    end
                end
                ST_SAMPLE: state <= ST_CONV;
                ST_CONV: begin
                    if (kill) begin
                        state <= ST_IDLE;
                        if (ab_chain_q) begin
                            if (cur_inj) inj_run  <= 1'b0;
                            else         norm_run <= 1'b0;
                        end
                    end else if (conv_done_i) begin
                        state <= ST_IDLE;
                    end
                end
                ST_PWDN: begin
                    if (!pwdn_i) begin
                        state    <= ST_WAKE;
                        wake_cnt <= WW'(WAKE_CYC);
                    end
                end
                ST_WAKE: begin
                    if (wake_cnt <= WW'(1)) state <= ST_IDLE;
                    else                    wake_cnt <= wake_cnt - WW'(1);
                end
                default: state <= ST_IDLE;
            endcase
            if (inj_go && !inj_run) begin
                inj_run <= 1'b1;
                inj_ptr <= '0;
            end
            if (norm_go && !norm_run) begin
                norm_run <= 1'b1;
                norm_ptr <= '0;
            end
        end
    end

    // Abort flags, the injected-abort flag and the start edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ab_conv_q    <= 1'b0;
            ab_chain_q   <= 1'b0;
            inj_abt_q    <= 1'b0;
            norm_start_d <= 1'b0;
            inj_start_d  <= 1'b0;
        end else begin
            ab_conv_q    <= abort_conv_i  | (ab_conv_q  & ~conv_start_o);
            ab_chain_q   <= abort_chain_i | (ab_chain_q & ~conv_start_o);
            if (inj_go && !inj_run)  inj_abt_q <= 1'b0;
            else if (kill && cur_inj) inj_abt_q <= 1'b1;
            norm_start_d <= norm_start_i;
            inj_start_d  <= inj_start_i;
        end
    end

    // Output mapping.
    always_comb begin
        conv_start_o       = (state == ST_SAMPLE);
        conv_chan_o        = chan_q;
        conv_abort_o       = kill;
        norm_busy_o        = norm_run;
        inj_busy_o         = inj_run;
        inj_aborted_o      = inj_abt_q;
        abort_conv_pend_o  = ab_conv_q;
        abort_chain_pend_o = ab_chain_q;
        chan_addr_o        = chan_q;
        status_o           = state;
    end
endmodule

// File: rtl/adc_chain_seq_chk.sv
// adc_chain_seq_chk: protocol checks on the sequencer's ports, bound to
// every adc_chain_seq instance.
module adc_chain_seq_chk #(
    parameter int NCH = 8,
    parameter int CW  = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           conv_start_o,
    input logic [CW-1:0]  conv_chan_o,
    input logic           conv_abort_o,
    input logic [NCH-1:0] norm_mask_i,
    input logic [NCH-1:0] inj_mask_i,
    input logic [2:0]     status_o
);
    // A request always names a channel enabled in one of the masks.
    assert_start_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> (norm_mask_i[conv_chan_o] || inj_mask_i[conv_chan_o]));

    // Only the defined status codes ever appear.
    assert_status_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 3'b000 || status_o == 3'b001 || status_o == 3'b010 ||
         status_o == 3'b100 || status_o == 3'b110));

    // The sampling cycle is always followed by the converting phase.
    assert_sample_then_conv_R12: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> (status_o == 3'b110));

    // After an abort the block returns to idle, without an immediate restart.
    assert_abort_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort_o |=> (status_o == 3'b000 && !conv_start_o));

    // While powered down, nothing is sent to the converter.
    assert_pwdn_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 3'b001) |-> (!conv_start_o && !conv_abort_o));
endmodule

bind adc_chain_seq adc_chain_seq_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_start_o(conv_start_o), .conv_chan_o(conv_chan_o),
    .conv_abort_o(conv_abort_o), .norm_mask_i(norm_mask_i), .inj_mask_i(inj_mask_i),
    .status_o(status_o)
);

// File: tb/tb_adc_chain_seq.sv
`timescale 1ns/1ps
// tb_adc_chain_seq: directed and seeded-random bench with a converter model.
module tb_adc_chain_seq;
    localparam int NCH = 8;
    localparam int CW  = 3;
    localparam int WAKE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic norm_start_i = 0, scan_mode_i = 0, inj_start_i = 0, inj_trig_en_i = 0;
    logic inj_edge_i = 0, inj_trig_i = 0, abort_conv_i = 0, abort_chain_i = 0;
    logic pwdn_i = 0, conv_done_i = 0;
    logic [NCH-1:0] norm_mask_i = '0, inj_mask_i = '0;
    logic conv_start_o, conv_abort_o, norm_busy_o, inj_busy_o, inj_aborted_o;
    logic abort_conv_pend_o, abort_chain_pend_o;
    logic [CW-1:0] conv_chan_o, chan_addr_o;
    logic [2:0] status_o;

    int tests = 0, fails = 0;
    int log_ch [0:1023];
    int log_n = 0, abort_seen = 0, cnt = 0, lat = 3;
    bit finished = 0;

    always #2.5 clk = ~clk;

    adc_chain_seq #(.NCH(NCH), .WAKE_CYC(WAKE)) dut (.*);

    // Converter model: records each request and answers lat cycles later.
    always @(negedge clk) begin
        conv_done_i = 1'b0;
        if (conv_abort_o) begin
            cnt = 0;
            abort_seen++;
        end else if (cnt == 1) begin
            conv_done_i = 1'b1;
        end
        if (cnt > 0) cnt--;
        if (conv_start_o) begin
            if (log_n < 1024) log_ch[log_n] = int'(conv_chan_o);
            log_n++;
            cnt = lat;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        int t = 0;
        do begin
            @(negedge clk);
            t++;
        end while ((norm_busy_o || inj_busy_o || status_o != 3'b000 || cnt != 0) && t < 5000);
    endtask

    task automatic wait_log(input int target);
        int t = 0;
        while (log_n < target && t < 5000) begin
            @(negedge clk);
            t++;
        end
    endtask

    function automatic int popc(input logic [NCH-1:0] m);
        int c = 0;
        for (int i = 0; i < NCH; i++) c += int'(m[i]);
        return c;
    endfunction

    // Mismatches between the log from base and one ascending pass of m.
    function automatic int seq_err(input int base, input logic [NCH-1:0] m);
        int p = base;
        int e = 0;
        for (int i = 0; i < NCH; i++) begin
            if (m[i]) begin
                if (log_ch[p] != i) e++;
                p++;
            end
        end
        return e;
    endfunction

    initial begin
        int base, e, n;
        logic [NCH-1:0] m;
        int exp_inj [6];
        void'($urandom(32'd20240611));
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R12: reset state
        check(status_o == 3'b000, "R12 reset status", int'(status_o), 0);
        check(!norm_busy_o && !inj_busy_o, "R12 reset busy", int'(norm_busy_o), 0);
        check(!conv_start_o, "R12 reset start", int'(conv_start_o), 0);

        // R1 R2: random one-shot chains with random converter latency
        for (int it = 0; it < 8; it++) begin
            m = NCH'($urandom);
            if (it == 0) m = 8'b1111_1111;
            lat = 1 + int'($urandom % 4);
            norm_mask_i = m;
            base = log_n;
            norm_start_i = 1; tick(1); norm_start_i = 0;
            wait_idle();
            check(log_n - base == popc(m), "R2 one-shot count", log_n - base, popc(m));
            e = seq_err(base, m);
            check(e == 0, "R1 ascending order", e, 0);
        end
        lat = 3;

        // R3: empty normal chain
        norm_mask_i = '0;
        base = log_n;
        norm_start_i = 1; tick(1); norm_start_i = 0;
        tick(3);
        check(!norm_busy_o && log_n == base, "R3 empty chain", int'(norm_busy_o) + log_n - base, 0);

        // R12: sampling cycle then converting phase, seen at the ports
        norm_mask_i = 8'b0000_0100;
        base = log_n;
        norm_start_i = 1; tick(1); norm_start_i = 0;
        while (!conv_start_o) tick(1);
        check(status_o == 3'b100, "R12 sampling code", int'(status_o), 4);
        tick(1);
        check(status_o == 3'b110, "R12 converting code", int'(status_o), 6);
        wait_idle();

        // R4: scan mode, stop lets the current pass finish
        m = 8'b1001_0010;
        norm_mask_i = m;
        scan_mode_i = 1;
        base = log_n;
        norm_start_i = 1;
        wait_log(base + 7);
        norm_start_i = 0;
        wait_idle();
        check(log_n - base == 9, "R4 scan whole passes", log_n - base, 9);
        e = seq_err(base, m) + seq_err(base + 3, m) + seq_err(base + 6, m);
        check(e == 0, "R4 scan pass order", e, 0);
        scan_mode_i = 0;

        // R5 R6 R7: injection during a normal conversion
        norm_mask_i = 8'b0110_0101;
        inj_mask_i  = 8'b1000_1000;
        exp_inj = '{0, 3, 7, 2, 5, 6};
        base = log_n;
        norm_start_i = 1; tick(1); norm_start_i = 0;
        wait_log(base + 1);
        tick(1);
        inj_start_i = 1; tick(1); inj_start_i = 0;
        wait_log(base + 2);
        tick(1);
        check(norm_busy_o && inj_busy_o, "R5 normal pending", int'(norm_busy_o), 1);
        wait_idle();
        e = 0;
        for (int i = 0; i < 6; i++) if (log_ch[base + i] != exp_inj[i]) e++;
        check(e == 0 && log_n - base == 6, "R7 pre-empt and resume", e, 0);

        // R6: injected chain alone, start lowered mid-chain
        inj_mask_i = 8'b0001_0110;
        base = log_n;
        inj_start_i = 1; tick(1);
        wait_log(base + 1);
        inj_start_i = 0;
        wait_idle();
        check(log_n - base == 3 && seq_err(base, inj_mask_i) == 0, "R6 injected chain", log_n - base, 3);

        // R8: external trigger edges
        inj_mask_i = 8'b1000_0001;
        inj_trig_en_i = 1; inj_edge_i = 1;
        base = log_n;
        inj_trig_i = 1; tick(1);
        wait_idle();
        check(log_n - base == 2, "R8 rising edge starts", log_n - base, 2);
        base = log_n;
        inj_trig_i = 0; tick(1);
        wait_idle();
        check(log_n - base == 0, "R8 falling ignored when rising set", log_n - base, 0);
        inj_trig_i = 1; tick(1);
        wait_idle();
        inj_edge_i = 0;
        base = log_n;
        inj_trig_i = 0; tick(1);
        wait_idle();
        check(log_n - base == 2, "R8 falling edge starts", log_n - base, 2);
        inj_trig_en_i = 0;
        base = log_n;
        inj_trig_i = 1; tick(2); inj_trig_i = 0; tick(2);
        wait_idle();
        check(log_n - base == 0, "R8 trigger disabled", log_n - base, 0);

        // R9: single-conversion abort keeps the chain going
        m = 8'b0010_1100;
        norm_mask_i = m;
        base = log_n;
        n = abort_seen;
        norm_start_i = 1; tick(1); norm_start_i = 0;
        wait_log(base + 1);
        tick(1);
        abort_conv_i = 1; tick(1); abort_conv_i = 0;
        check(abort_conv_pend_o && conv_abort_o, "R9 abort armed", int'(abort_conv_pend_o), 1);
        wait_idle();
        check(abort_seen - n == 1, "R9 abort issued", abort_seen - n, 1);
        check(log_n - base == 3 && seq_err(base, m) == 0, "R9 chain continues", log_n - base, 3);
        check(!abort_conv_pend_o, "R9 flag cleared", int'(abort_conv_pend_o), 0);

        // R10: chain abort on a normal chain
        norm_mask_i = 8'b1111_0000;
        base = log_n;
        norm_start_i = 1; tick(1); norm_start_i = 0;
        wait_log(base + 1);
        tick(1);
        abort_chain_i = 1; tick(1); abort_chain_i = 0;
        wait_idle();
        check(log_n - base == 1 && !norm_busy_o, "R10 normal chain ended", log_n - base, 1);
        check(abort_chain_pend_o, "R10 flag held", int'(abort_chain_pend_o), 1);

        // R10: chain abort on an injected chain, then the flag clears
        inj_mask_i = 8'b0000_0110;
        base = log_n;
        inj_start_i = 1; tick(1); inj_start_i = 0;
        wait_log(base + 1);
        tick(1);
        check(!abort_chain_pend_o, "R10 flag cleared on request", int'(abort_chain_pend_o), 0);
        abort_chain_i = 1; tick(1); abort_chain_i = 0;
        wait_idle();
        check(log_n - base == 1 && inj_aborted_o, "R10 injected aborted", int'(inj_aborted_o), 1);
        inj_start_i = 1; tick(1); inj_start_i = 0;
        check(!inj_aborted_o, "R10 aborted flag cleared", int'(inj_aborted_o), 1'b0);
        wait_idle();

        // R11: power-down and wake sequence
        pwdn_i = 1; tick(1);
        check(status_o == 3'b001, "R11 powered down", int'(status_o), 1);
        tick(3);
        check(status_o == 3'b001, "R11 stays down", int'(status_o), 1);
        pwdn_i = 0; tick(1);
        n = 0;
        while (status_o == 3'b010 && n < 100) begin
            n++;
            tick(1);
        end
        check(n == WAKE, "R11 wake length", n, WAKE);
        check(status_o == 3'b000, "R11 back to idle", int'(status_o), 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule